// File: doc/BRIEF.md
# Input Change Interrupt Generator

This block watches a parallel port and raises an interrupt request when any pin that is set up as an input no longer matches the value stored in the port's input snapshot register. Pin levels come from the outside world, so they first pass through a synchronizer chain. After that they are compared bit by bit against the snapshot. The comparison ignores every pin whose direction bit marks it as an output. The request is a level, not a latched edge. It goes away on its own when the changed inputs return to their stored levels. It is also cleared when the serial slave logic reads the input register. That read copies the current synchronized pins into the snapshot.

The interrupt leaves the block as a pull-low enable for an open-drain pad. The pad either sinks the line or lets it float, and it never drives it high. The snapshot value is also an output, so the register read path can return it. Reset is synchronous. While reset is held, the synchronizer and the snapshot both load the live pin levels, so the request starts released.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `snap_q` takes the present `pin_raw` value and `irq_pull_low` is 0. Once the pins stay steady after reset, no request is raised.
- R2: If the level of an input pin (direction bit 1) changes in either direction away from its `snap_q` bit, `irq_pull_low` becomes 1 on the third rising clock edge after the change. The first two edges pass through the synchronizer and the third sets the flag.
- R3: If all differing input pins return to their `snap_q` levels with no read, `irq_pull_low` returns to 0 on the third rising edge after the return.
- R4: If `rd_snap` is 1 at a rising edge, `snap_q` loads the synchronized pins and `irq_pull_low` is 0 after that edge. When pins stay steady, the request stays released afterwards.
- R5: A pin whose direction bit is 0 (output) never makes `irq_pull_low` 1, whatever its level.
- R6: If a pin's direction bit changes from 0 to 1 while its synchronized level differs from its `snap_q` bit, `irq_pull_low` becomes 1 on the first rising edge after the change.
- R7: When `rd_snap` is 0, `snap_q` holds its value whatever the pins and direction bits do.
- R8: A change that reaches the comparator at the edge where `rd_snap` is 1 is absorbed into `snap_q` and raises no request.
- R9: `irq_pull_low` is a pull-low enable. A value of 1 means sink the pad line and 0 means release it. The block has no drive-high state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | WIDTH | Asynchronous pin levels |
| dir_in | input | WIDTH | Direction per pin, 1 = input, 0 = output |
| rd_snap | input | 1 | One-cycle strobe from the slave when the input register is read |
| irq_pull_low | output | 1 | Open-drain enable, 1 = pull interrupt line low |
| snap_q | output | WIDTH | Stored input snapshot |

## Verification
The hardest case to reach from the ports is a pin change that reaches the comparator on exactly the edge where the read strobe is sampled, so that the change is absorbed instead of raising a request. The bench gets there by counting the synchronizer latency. It drives the pin on a falling edge and raises `rd_snap` so that the strobe is sampled on the third rising edge. A second hard case is a direction switch with a stale snapshot. It is reached by taking a snapshot, changing pins that are set as outputs, and then flipping them to inputs. Randomized pin, direction and read patterns cover the rest, and each pattern is given time to settle before it is checked.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  typedef enum logic {
    PAD_RELEASE  = 1'b0,
    PAD_PULL_LOW = 1'b1
  } pad_drive_e;

  localparam logic DIR_INPUT  = 1'b1;
  localparam logic DIR_OUTPUT = 1'b0;
endpackage

// File: rtl/pci_sync_chain.sv
module pci_sync_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        stage_q[s] <= d_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= d_async;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pci_detect.sv
module pci_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] dir_in,
  input  logic             rd_snap,
  output logic [WIDTH-1:0] snap_q,
  output logic [WIDTH-1:0] diff_hits,
  output logic             irq_flag
);
  import pin_change_irq_pkg::*;

  function automatic logic [WIDTH-1:0] live_diff(
    input logic [WIDTH-1:0] pins,
    input logic [WIDTH-1:0] snap,
    input logic [WIDTH-1:0] dirs
  );
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      r[i] = (pins[i] != snap[i]) && (dirs[i] == DIR_INPUT);
    end
    return r;
  endfunction

  assign diff_hits = live_diff(pin_sync, snap_q, dir_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q   <= pin_raw;
      irq_flag <= 1'b0;
    end else begin
      if (rd_snap) snap_q <= pin_sync;
      irq_flag <= rd_snap ? 1'b0 : (|diff_hits);
    end
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  input  logic [WIDTH-1:0] dir_in,
  input  logic             rd_snap,
  output logic             irq_pull_low,
  output logic [WIDTH-1:0] snap_q
);
  import pin_change_irq_pkg::*;

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] diff_hits;
  logic             irq_flag;
  pad_drive_e       pad_state;

  pci_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .q_sync  (pin_sync)
  );

  pci_detect #(.WIDTH(WIDTH)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .pin_sync  (pin_sync),
    .dir_in    (dir_in),
    .rd_snap   (rd_snap),
    .snap_q    (snap_q),
    .diff_hits (diff_hits),
    .irq_flag  (irq_flag)
  );

  assign pad_state    = irq_flag ? PAD_PULL_LOW : PAD_RELEASE;
  assign irq_pull_low = (pad_state == PAD_PULL_LOW);
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dir_in,
  input logic             rd_snap,
  input logic             irq_pull_low,
  input logic [WIDTH-1:0] snap_q,
  input logic [WIDTH-1:0] pin_sync,
  input logic [WIDTH-1:0] diff_hits
);
  p_read_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_snap |=> !irq_pull_low);

  p_read_loads_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_snap |=> (snap_q == $past(pin_sync)));

  p_snap_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_snap |=> $stable(snap_q));

  p_outputs_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dir_in) == '0) |-> !irq_pull_low);

  p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_low) |-> ($past(diff_hits) != '0));
endmodule

bind pin_change_irq pin_change_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dir_in       (dir_in),
  .rd_snap      (rd_snap),
  .irq_pull_low (irq_pull_low),
  .snap_q       (snap_q),
  .pin_sync     (pin_sync),
  .diff_hits    (diff_hits)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_raw = 8'h5A;
  logic [W-1:0] dir_in = 8'hFF;
  logic         rd_snap = 1'b0;
  logic         irq_pull_low;
  logic [W-1:0] snap_q;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_snap;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .dir_in(dir_in),
    .rd_snap(rd_snap), .irq_pull_low(irq_pull_low), .snap_q(snap_q)
  );

  function automatic logic want_irq(input logic [W-1:0] p, input logic [W-1:0] s,
                                    input logic [W-1:0] d);
    logic any = 1'b0;
    for (int i = 0; i < W; i++) if (d[i] && (p[i] ^ s[i])) any = 1'b1;
    return any;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_read();
    to_neg();
    rd_snap = 1'b1;
    step(1);
    rd_snap = 1'b0;
    exp_snap = pin_raw;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    chk("R1 snap", snap_q, 8'h5A);
    chk("R1 irq", {7'd0, irq_pull_low}, 8'd0);
    to_neg(); rst_n = 1'b1;
    exp_snap = 8'h5A;
    step(4);
    chk("R1 steady", {7'd0, irq_pull_low}, 8'd0);

    // R2 rising change, exact latency
    to_neg(); pin_raw = 8'h5B;
    step(2);
    chk("R2 not yet", {7'd0, irq_pull_low}, 8'd0);
    step(1);
    chk("R2 set", {7'd0, irq_pull_low}, 8'd1);
    chk("R9 pull low", {7'd0, irq_pull_low}, 8'd1);
    // R3 return releases
    to_neg(); pin_raw = 8'h5A;
    step(2);
    chk("R3 still", {7'd0, irq_pull_low}, 8'd1);
    step(1);
    chk("R3 release", {7'd0, irq_pull_low}, 8'd0);
    // R2 falling change
    to_neg(); pin_raw = 8'h1A;
    step(3);
    chk("R2 fall", {7'd0, irq_pull_low}, 8'd1);
    // R4 read
    do_read();
    chk("R4 irq", {7'd0, irq_pull_low}, 8'd0);
    chk("R4 snap", snap_q, 8'h1A);
    step(3);
    chk("R4 stays", {7'd0, irq_pull_low}, 8'd0);

    // R5 outputs masked, R7 snapshot holds, then R6 switch to input
    to_neg(); dir_in = 8'h0F; pin_raw = 8'hEA;
    step(5);
    chk("R5 masked", {7'd0, irq_pull_low}, 8'd0);
    chk("R7 hold", snap_q, 8'h1A);
    to_neg(); dir_in = 8'h1F;
    step(1);
    chk("R6 switch", {7'd0, irq_pull_low}, 8'd1);
    to_neg(); dir_in = 8'hFF;
    do_read();
    step(2);

    // R8 change landing on the read edge is absorbed
    to_neg(); pin_raw = pin_raw ^ 8'h80;
    step(2);
    to_neg(); rd_snap = 1'b1;
    step(1);
    rd_snap = 1'b0;
    exp_snap = pin_raw;
    chk("R8 snap", snap_q, exp_snap);
    step(4);
    chk("R8 lost", {7'd0, irq_pull_low}, 8'd0);

    // random patterns
    for (int it = 0; it < 60; it++) begin
      to_neg();
      pin_raw = W'($urandom);
      dir_in  = W'($urandom);
      step(4);
      chk("R2/R5 rand irq", {7'd0, irq_pull_low}, {7'd0, want_irq(pin_raw, exp_snap, dir_in)});
      chk("R7 rand snap", snap_q, exp_snap);
      if ($urandom_range(0, 2) == 0) begin
        do_read();
        chk("R4 rand read", snap_q, exp_snap);
        step(2);
        chk("R4 rand quiet", {7'd0, irq_pull_low}, 8'd0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule